// File: doc/BRIEF.md
# Timer Event Request Router

This block sits next to a state-configurable timer and turns the timer's per-event pulses and its match-reload strobe into two DMA request lines and one interrupt line. Each DMA request line has a control register with an event mask and a reload-trigger enable. A trigger sets the request, and the request stays high until the DMA controller acknowledges it on that channel's acknowledge input. Software can read the live request state through a read-only status bit.

The interrupt line is combinational. It is high whenever an event flag coming from the timer's flag storage lines up with a set bit in the interrupt-enable register. The registers sit on a simple 32-bit word-indexed bus with a fixed one-cycle response. The DMA control registers accept only full-word writes. A byte or half-word write to them is answered with a one-cycle error and is otherwise discarded. The reset input is expected to be synchronised outside the block, so that it deasserts synchronously.

Top module: `evt_req_router`

## Requirements
- R1: After reset, both DMA request outputs and the interrupt output are low, and every register reads as zero.
- R2: Bits 5:0 of DMA control register k (word index k, k = 0 or 1) are an event mask. A pulse on event n (n in 0..5) with mask bit n set drives dma_req[k] high on the next clock edge. Events whose mask bit is clear, and events 6 and 7, have no effect on DMA requests.
- R3: When bit 30 of DMA control register k is set, a reload strobe drives dma_req[k] high on the next clock edge. When bit 30 is clear, the strobe has no effect.
- R4: A raised request stays high until dma_ack[k] is seen without a trigger on that channel. The request is then low from the next clock edge on.
- R5: If a trigger for channel k arrives in the same cycle as dma_ack[k], the request stays high.
- R6: Reading a DMA control register returns bit 31 equal to the current dma_req[k], returns bits 29:6 as zero, and returns the stored mask and reload enable. A write to bit 31 or to bits 29:6 changes nothing.
- R7: bus_size encodes 0 = byte, 1 = half-word and 2 = word. A write to a DMA control register with a size other than word returns bus_err high together with bus_ready, and leaves the register unchanged. A word-sized write returns no error.
- R8: The interrupt-enable register (word index 2) stores bits 7:0 on a write of any size. Bits 31:8 read as zero.
- R9: irq is high in the same cycle whenever some bit position is one in both the interrupt-enable register and evt_flags. Otherwise irq is low.
- R10: Every bus access gets bus_ready for exactly one cycle, in the cycle after bus_valid, with read data in bus_rdata. An access to an unmapped word index reads zero, changes no state and raises no error.
- R11: The two DMA channels are independent. A trigger or acknowledge on one channel does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_size | input | 2 | Write size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response strobe, one cycle after bus_valid |
| bus_err | output | 1 | Error response, valid with bus_ready |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| evt_pulse | input | 8 | One pulse line per timer event |
| reload_strobe | input | 1 | Match registers loaded from reload registers |
| evt_flags | input | 8 | Event flag vector from the timer |
| dma_ack | input | 2 | Per-channel DMA service acknowledge |
| dma_req | output | 2 | Sticky DMA request lines |
| irq | output | 1 | Combined event interrupt |

## Verification
A vector table sweeps pairs of enable and flag patterns: disjoint bits, one shared bit at the top and bottom positions, all ones, and all zeros. These separate an AND-then-OR reduction from plain OR or single-side logic. Directed tests cover single matching and non-matching event bits, events above the mask width, and the reload path with its enable on and off. They also hit the acknowledge that collides with a trigger, which distinguishes set priority from clear priority. Writes of each size to each register class show whether size checking is limited to the DMA registers. Status-bit reads taken before and after acknowledge, with the other channel left idle, expose cross-channel coupling.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bus_size_e;

  localparam int unsigned RELOAD_BIT = 30;
  localparam int unsigned STATUS_BIT = 31;
endpackage

// File: rtl/evt_dma_chan.sv
module evt_dma_chan #(
  parameter int unsigned MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] mask,
  input  logic              reload_en,
  input  logic [MASK_W-1:0] evt,
  input  logic              reload_strobe,
  input  logic              ack,
  output logic              req
);
  logic trig;
  logic req_d;

  always_comb begin
    trig  = (|(mask & evt)) | (reload_en & reload_strobe);
    // a new trigger wins over a simultaneous acknowledge
    req_d = trig | (req & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_d;
  end
endmodule

// File: rtl/evt_irq_comb.sv
module evt_irq_comb #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] enables,
  input  logic [IRQ_W-1:0] flags,
  output logic             irq
);
  always_comb irq = |(enables & flags);
endmodule

// File: rtl/evt_bus_regs.sv
module evt_bus_regs
  import evt_router_pkg::*;
#(
  parameter int unsigned NUM_DMA = 2,
  parameter int unsigned MASK_W  = 6,
  parameter int unsigned IRQ_W   = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [1:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic                      bus_ready,
  output logic                      bus_err,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_DMA-1:0]        dma_req,
  output logic [NUM_DMA-1:0][MASK_W-1:0] mask_q,
  output logic [NUM_DMA-1:0]        reload_q,
  output logic [IRQ_W-1:0]          ien_q
);
  localparam int unsigned RSV_W   = RELOAD_BIT - MASK_W;
  localparam int unsigned IEN_IDX = NUM_DMA;

  logic [NUM_DMA-1:0][MASK_W-1:0] mask_d;
  logic [NUM_DMA-1:0]             reload_d;
  logic [IRQ_W-1:0]               ien_d;
  logic                           ready_d, err_d;
  logic [31:0]                    rdata_d;
  logic                           is_word;
  logic                           hit_ien;
  logic [NUM_DMA-1:0]             hit_dma;

  always_comb begin
    is_word = (bus_size == SZ_WORD);
    hit_ien = (bus_addr == ADDR_W'(IEN_IDX));
    for (int k = 0; k < NUM_DMA; k++) hit_dma[k] = (bus_addr == ADDR_W'(k));
  end

  always_comb begin
    mask_d   = mask_q;
    reload_d = reload_q;
    ien_d    = ien_q;
    ready_d  = bus_valid;
    err_d    = 1'b0;
    rdata_d  = '0;
    if (bus_valid && bus_write) begin
      for (int k = 0; k < NUM_DMA; k++) begin
        if (hit_dma[k]) begin
          if (is_word) begin
            mask_d[k]   = bus_wdata[MASK_W-1:0];
            reload_d[k] = bus_wdata[RELOAD_BIT];
          end else begin
            err_d = 1'b1;
          end
        end
      end
      if (hit_ien) ien_d = bus_wdata[IRQ_W-1:0];
    end
    if (bus_valid && !bus_write) begin
      for (int k = 0; k < NUM_DMA; k++) begin
        if (hit_dma[k])
          rdata_d = {dma_req[k], reload_q[k], {RSV_W{1'b0}}, mask_q[k]};
      end
      if (hit_ien) rdata_d = {{(32-IRQ_W){1'b0}}, ien_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      reload_q  <= '0;
      ien_q     <= '0;
      bus_ready <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      mask_q    <= mask_d;
      reload_q  <= reload_d;
      ien_q     <= ien_d;
      bus_ready <= ready_d;
      bus_err   <= err_d;
      bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/evt_req_router.sv
module evt_req_router #(
  parameter int unsigned NUM_DMA = 2,
  parameter int unsigned MASK_W  = 6,
  parameter int unsigned IRQ_W   = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [31:0]        bus_wdata,
  output logic               bus_ready,
  output logic               bus_err,
  output logic [31:0]        bus_rdata,
  input  logic [IRQ_W-1:0]   evt_pulse,
  input  logic               reload_strobe,
  input  logic [IRQ_W-1:0]   evt_flags,
  input  logic [NUM_DMA-1:0] dma_ack,
  output logic [NUM_DMA-1:0] dma_req,
  output logic               irq
);
  logic [NUM_DMA-1:0][MASK_W-1:0] mask_q;
  logic [NUM_DMA-1:0]             reload_q;
  logic [IRQ_W-1:0]               ien_q;

  evt_bus_regs #(
    .NUM_DMA(NUM_DMA), .MASK_W(MASK_W), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .mask_q(mask_q), .reload_q(reload_q), .ien_q(ien_q)
  );

  for (genvar k = 0; k < NUM_DMA; k++) begin : g_chan
    evt_dma_chan #(.MASK_W(MASK_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .mask(mask_q[k]), .reload_en(reload_q[k]),
      .evt(evt_pulse[MASK_W-1:0]), .reload_strobe(reload_strobe),
      .ack(dma_ack[k]), .req(dma_req[k])
    );
  end

  evt_irq_comb #(.IRQ_W(IRQ_W)) u_irq (
    .enables(ien_q), .flags(evt_flags), .irq(irq)
  );
endmodule

// File: rtl/evt_req_router_chk.sv
module evt_req_router_chk #(
  parameter int unsigned NUM_DMA = 2,
  parameter int unsigned IRQ_W   = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_size,
  input logic               bus_ready,
  input logic               bus_err,
  input logic [IRQ_W-1:0]   evt_pulse,
  input logic               reload_strobe,
  input logic [IRQ_W-1:0]   evt_flags,
  input logic [NUM_DMA-1:0] dma_ack,
  input logic [NUM_DMA-1:0] dma_req,
  input logic               irq
);
  assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_ready);

  assert_err_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready);

  assert_short_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size != 2'd2 && bus_addr < ADDR_W'(NUM_DMA))
    |=> bus_err);

  assert_no_flag_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flags == '0) |-> !irq);

  for (genvar k = 0; k < NUM_DMA; k++) begin : g_chk
    assert_sticky_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[k] && !dma_ack[k]) |=> dma_req[k]);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack[k] && evt_pulse == '0 && !reload_strobe) |=> !dma_req[k]);

    assert_idle_no_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_req[k] && evt_pulse == '0 && !reload_strobe) |=> !dma_req[k]);
  end
endmodule

bind evt_req_router evt_req_router_chk #(
  .NUM_DMA(NUM_DMA), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_ready(bus_ready),
  .bus_err(bus_err), .evt_pulse(evt_pulse), .reload_strobe(reload_strobe),
  .evt_flags(evt_flags), .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq)
);

// File: tb/evt_req_router_tb.sv
module evt_req_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_err;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        reload_strobe = 1'b0;
  logic [7:0]  evt_flags = '0;
  logic [1:0]  dma_ack = '0;
  logic [1:0]  dma_req;
  logic        irq;

  int checks = 0;
  int failures = 0;
  logic        r_err;
  logic [31:0] r_data;

  always #2.5 clk = ~clk;

  evt_req_router u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .reload_strobe(reload_strobe), .evt_flags(evt_flags),
    .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq)
  );

  // {ien, flags, expected irq}
  localparam logic [16:0] IRQ_VEC [6] = '{
    {8'h0F, 8'hF0, 1'b0},
    {8'h80, 8'h80, 1'b1},
    {8'h01, 8'h01, 1'b1},
    {8'hFF, 8'hFF, 1'b1},
    {8'h00, 8'hFF, 1'b0},
    {8'h5A, 8'hA5, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_acc(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                         input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R10 ready", {31'b0, bus_ready}, 32'd1);
    r_err = bus_err; r_data = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] ev, input logic rl, input logic [1:0] ack);
    @(negedge clk);
    evt_pulse = ev; reload_strobe = rl; dma_ack = ack;
    @(negedge clk);
    evt_pulse = '0; reload_strobe = 1'b0; dma_ack = '0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 dma_req", {30'b0, dma_req}, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    bus_acc(1'b0, 4'd0, 2'd2, '0); check("R1 reg0", r_data, 32'd0);
    bus_acc(1'b0, 4'd2, 2'd2, '0); check("R1 ien", r_data, 32'd0);

    // R9 vector table
    for (int i = 0; i < 6; i++) begin
      bus_acc(1'b1, 4'd2, 2'd2, {24'b0, IRQ_VEC[i][16:9]});
      evt_flags = IRQ_VEC[i][8:1];
      #1;
      check("R9 irq", {31'b0, irq}, {31'b0, IRQ_VEC[i][0]});
    end
    evt_flags = '0;

    // R8 byte write to ien accepted, reserved bits zero
    bus_acc(1'b1, 4'd2, 2'd0, 32'hFFFF_FF3C);
    check("R8 no err", {31'b0, r_err}, 32'd0);
    bus_acc(1'b0, 4'd2, 2'd2, '0); check("R8 ien readback", r_data, 32'h3C);

    // R6 write mask with reserved and status bits set
    bus_acc(1'b1, 4'd0, 2'd2, 32'hBFFF_FFC4);
    check("R7 word no err", {31'b0, r_err}, 32'd0);
    bus_acc(1'b0, 4'd0, 2'd2, '0);
    check("R6 readback", r_data, 32'h0000_0004);

    // R2 unmasked event and events 6,7 ignored
    pulse(8'hC3, 1'b0, 2'b00);
    check("R2 unmasked ignored", {30'b0, dma_req}, 32'd0);
    // R2 matching event raises ch0 only (R11)
    pulse(8'h04, 1'b0, 2'b00);
    check("R2 masked event", {30'b0, dma_req}, 32'd1);
    bus_acc(1'b0, 4'd0, 2'd2, '0);
    check("R6 status bit", r_data, 32'h8000_0004);
    bus_acc(1'b0, 4'd1, 2'd2, '0);
    check("R11 other chan idle", r_data, 32'd0);

    // R4 sticky then ack clears
    repeat (3) @(negedge clk);
    check("R4 sticky", {30'b0, dma_req}, 32'd1);
    pulse(8'h00, 1'b0, 2'b10);
    check("R11 ack other chan", {30'b0, dma_req}, 32'd1);
    pulse(8'h00, 1'b0, 2'b01);
    check("R4 ack clears", {30'b0, dma_req}, 32'd0);

    // R5 trigger with ack keeps set
    pulse(8'h04, 1'b0, 2'b01);
    check("R5 trigger wins", {30'b0, dma_req}, 32'd1);
    pulse(8'h00, 1'b0, 2'b01);

    // R7 half and byte writes rejected
    bus_acc(1'b1, 4'd0, 2'd1, 32'h4000_003F);
    check("R7 half err", {31'b0, r_err}, 32'd1);
    bus_acc(1'b1, 4'd1, 2'd0, 32'h0000_003F);
    check("R7 byte err", {31'b0, r_err}, 32'd1);
    bus_acc(1'b0, 4'd0, 2'd2, '0);
    check("R7 unchanged", r_data, 32'h0000_0004);

    // R3 reload path on ch1
    pulse(8'h00, 1'b1, 2'b00);
    check("R3 reload disabled", {30'b0, dma_req}, 32'd0);
    bus_acc(1'b1, 4'd1, 2'd2, 32'h4000_0000);
    pulse(8'h00, 1'b1, 2'b00);
    check("R3 reload raises", {30'b0, dma_req}, 32'd2);
    bus_acc(1'b0, 4'd1, 2'd2, '0);
    check("R6 reload status", r_data, 32'hC000_0000);

    // R10 unmapped access
    bus_acc(1'b1, 4'd7, 2'd1, 32'hFFFF_FFFF);
    check("R10 unmapped no err", {31'b0, r_err}, 32'd0);
    bus_acc(1'b0, 4'd7, 2'd2, '0);
    check("R10 unmapped reads 0", r_data, 32'd0);
    @(negedge clk);
    check("R10 ready single", {31'b0, bus_ready}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule